// File: doc/BRIEF.md
# Dual Programmable Down-Counter Timer

This peripheral holds two identical down-counting timers and one interrupt status unit they share, all reached through a simple register port. A write completes in the clock cycle it is presented. A read is combinational on the address. Each timer keeps three values: a divisor, a live count that can only be read, and a control word.

The control word carries an operation in bits [1:0] and a tick source in bits [4:2]. The operation is one of:
- load: copy the divisor into the count and stop;
- hold: freeze the count;
- run: count down on ticks.

Source codes 4 to 7 take their ticks from the clock-enable inputs `tick_en[0]` to `tick_en[3]`. Codes 0 to 3 give no ticks at all.

A running timer decrements once per selected tick. When a tick arrives with the count at one or zero, the count reloads from the divisor and the timer's raw interrupt bit sets. Timer 0 owns bit 0 and timer 1 owns bit 1. Software enables bits through a mask, clears them by writing ones to the acknowledge location, and sees both the raw and the masked view. The single level interrupt output is high while any masked bit is set. A free-running cycle counter can also be read.

Top module: `dual_tick_timer`

Register offsets (byte addresses):

| Offset | Contents |
|--------|----------|
| 0x00 | timer 0 divisor |
| 0x04 | timer 0 count |
| 0x08 | timer 0 control |
| 0x10 | timer 1 divisor |
| 0x14 | timer 1 count |
| 0x18 | timer 1 control |
| 0x38 | time counter |
| 0x48 | mask |
| 0x4C | acknowledge |
| 0x50 | raw status |
| 0x54 | masked status |

## Requirements
- R1: After reset, `irq_o` is low and the following read zero: both counts, both divisors, both controls, the mask, raw status and masked status. Both timers are stopped.
- R2: Writing a divisor (offset 0x00 or 0x10) stores the value, which reads back at the same offset, and leaves the count unchanged.
- R3: Writing a control word with operation 0 copies the divisor into the count and stops the timer.
- R4: Writing a control word with operation 1 stops the timer, and the count stays frozen whatever ticks arrive.
- R5: With operation 2, the count drops by one on each clock in which the selected tick input is high. Source code s in 4..7 selects `tick_en[s-4]`. Ticks on inputs that are not selected have no effect.
- R6: A tick that finds the count at 1 or 0 reloads the count from the divisor and sets raw bit n for timer n on the following clock.
- R7: The mask (0x48, bits [1:0]) reads back as written. Masked status (0x54) equals raw AND mask. `irq_o` is high exactly when masked status is non-zero.
- R8: A write to 0x4C clears each raw bit whose written bit is 1. If an expiry sets the same bit in the same cycle, the bit stays set.
- R9: The time counter at 0x38 increases by one every clock.
- R10: Reads of unmapped offsets return zero. Writes to them change no register and do not change `irq_o`.
- R11: A running timer whose source code is 0 to 3 does not advance. Operation code 3 behaves as hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 4 | Tick enables for source codes 4 to 7 |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt, high while any masked bit is set |

## Verification
The bound checker watches these on every cycle:
- each expiry lands in its raw bit;
- an acknowledge with no competing expiry clears its bit;
- a zero mask drops the interrupt;
- a divisor write leaves a stopped count alone;
- the time counter steps by one.

Only the bench scenarios can show the sequence-level behaviours:
- the exact count after a run of ticks;
- that unselected tick inputs and sources 0 to 3 are ignored;
- that operation 3 holds;
- the acknowledge-versus-expiry race;
- the readback of each register.

// File: rtl/dtt_pkg.sv
// Package: shared operation codes and register offsets for the dual timer.
// Assumes byte offsets of 7 bits and a 5-bit control field.
package dtt_pkg;
    localparam int OFF_W  = 7;
    localparam int CTRL_W = 5;
    localparam int NSRC   = 4;
    localparam int NTMR   = 2;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    // Per-timer layout: the base is timer index times this stride.
    localparam logic [OFF_W-1:0] TMR_STRIDE = 7'h10;
    localparam logic [OFF_W-1:0] SUB_DIV    = 7'h00;
    localparam logic [OFF_W-1:0] SUB_CNT    = 7'h04;
    localparam logic [OFF_W-1:0] SUB_CTRL   = 7'h08;
    localparam logic [OFF_W-1:0] OFF_TIME   = 7'h38;
    localparam logic [OFF_W-1:0] OFF_MASK   = 7'h48;
    localparam logic [OFF_W-1:0] OFF_ACK    = 7'h4C;
    localparam logic [OFF_W-1:0] OFF_RAW    = 7'h50;
    localparam logic [OFF_W-1:0] OFF_MSKD   = 7'h54;
endpackage

// File: rtl/dtt_counter.sv
// Module: one programmable down-counter with divisor and control word.
// Assumes the divisor and control writes never arrive in the same cycle.
// A control write takes priority over any tick in that cycle.
module dtt_counter
    import dtt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  div_wr,
    input  logic                  ctrl_wr,
    input  logic [CNT_W-1:0]      wdata,
    input  logic [NSRC-1:0]       tick_en,
    output logic [CNT_W-1:0]      div_q,
    output logic [CTRL_W-1:0]     ctrl_q,
    output logic [CNT_W-1:0]      count_q,
    output logic                  running,
    output logic                  expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [2:0] src_sel;
    logic       tick_hit;
    logic       at_end;
    op_e        new_op;

    // Pick the selected tick input; codes below 4 never tick.
    always_comb begin
        src_sel  = ctrl_q[4:2];
        tick_hit = src_sel[2] & tick_en[src_sel[1:0]];
        at_end   = (count_q <= ONE);
        new_op   = op_e'(wdata[1:0]);
    end

    assign expire = running & tick_hit & ~ctrl_wr & at_end;

    // Divisor, control, count and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            ctrl_q  <= '0;
            count_q <= '0;
            running <= 1'b0;
        end else begin
            if (div_wr)
                div_q <= wdata;
            if (ctrl_wr) begin
                ctrl_q <= wdata[CTRL_W-1:0];
                case (new_op)
                    OP_LOAD: begin
                        count_q <= div_q;
                        running <= 1'b0;
                    end
                    OP_RUN:  running <= 1'b1;
                    default: running <= 1'b0;
                endcase
            end else if (running && tick_hit) begin
                count_q <= at_end ? div_q : count_q - ONE;
            end
        end
    end
endmodule

// File: rtl/dtt_irq.sv
// Module: raw/mask/acknowledge interrupt status with a level output.
// Assumes the expiry pulses last one cycle; on a race with an
// acknowledge, the expiry wins.
module dtt_irq #(
    parameter int NBIT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_wr,
    input  logic            ack_wr,
    input  logic [NBIT-1:0] wdata,
    input  logic [NBIT-1:0] expire,
    output logic [NBIT-1:0] raw_q,
    output logic [NBIT-1:0] mask_q,
    output logic            irq_o
);
    logic [NBIT-1:0] clr;

    // Bits to clear this cycle.
    always_comb clr = ack_wr ? wdata : '0;

    // Raw and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | expire;
            if (mask_wr)
                mask_q <= wdata;
        end
    end

    // Level output from the stored state.
    always_comb irq_o = |(raw_q & mask_q);
endmodule

// File: rtl/dtt_timebase.sv
// Module: free-running cycle counter; wraps at its width.
module dtt_timebase #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] time_q
);
    // Advance once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_q + TIME_W'(1);
    end
endmodule

// File: rtl/dual_tick_timer.sv
// Module: top of the dual timer.
// It decodes the single-cycle register port, instantiates two counters,
// the interrupt unit and the timebase, and muxes read data.
// Assumes DATA_W is at least CTRL_W.
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [DATA_W-1:0] div_v  [NTMR];
    logic [DATA_W-1:0] cnt_v  [NTMR];
    logic [CTRL_W-1:0] ctrl_v [NTMR];
    logic [NTMR-1:0]   run_vec;
    logic [NTMR-1:0]   exp_vec;
    logic [NTMR-1:0]   raw_stat;
    logic [NTMR-1:0]   mask_stat;
    logic [DATA_W-1:0] time_val;
    logic [DATA_W-1:0] cnt0;

    for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(gi * 16);
        logic div_wr, ctrl_wr;

        // Write decode for this timer.
        always_comb begin
            div_wr  = bus_wr && (bus_addr == BASE + ADDR_W'(SUB_DIV));
            ctrl_wr = bus_wr && (bus_addr == BASE + ADDR_W'(SUB_CTRL));
        end

        dtt_counter #(.CNT_W(DATA_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .div_wr  (div_wr),
            .ctrl_wr (ctrl_wr),
            .wdata   (bus_wdata),
            .tick_en (tick_en),
            .div_q   (div_v[gi]),
            .ctrl_q  (ctrl_v[gi]),
            .count_q (cnt_v[gi]),
            .running (run_vec[gi]),
            .expire  (exp_vec[gi])
        );
    end

    assign cnt0 = cnt_v[0];

    logic mask_wr, ack_wr;

    // Write decode for the interrupt unit.
    always_comb begin
        mask_wr = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
        ack_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_ACK));
    end

    dtt_irq #(.NBIT(NTMR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (mask_wr),
        .ack_wr  (ack_wr),
        .wdata   (bus_wdata[NTMR-1:0]),
        .expire  (exp_vec),
        .raw_q   (raw_stat),
        .mask_q  (mask_stat),
        .irq_o   (irq_o)
    );

    dtt_timebase #(.TIME_W(DATA_W)) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .time_q (time_val)
    );

    // Read data mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(SUB_DIV):               bus_rdata = div_v[0];
            ADDR_W'(SUB_CNT):               bus_rdata = cnt_v[0];
            ADDR_W'(SUB_CTRL):              bus_rdata = DATA_W'(ctrl_v[0]);
            ADDR_W'(TMR_STRIDE + SUB_DIV):  bus_rdata = div_v[1];
            ADDR_W'(TMR_STRIDE + SUB_CNT):  bus_rdata = cnt_v[1];
            ADDR_W'(TMR_STRIDE + SUB_CTRL): bus_rdata = DATA_W'(ctrl_v[1]);
            ADDR_W'(OFF_TIME):              bus_rdata = time_val;
            ADDR_W'(OFF_MASK):              bus_rdata = DATA_W'(mask_stat);
            ADDR_W'(OFF_RAW):               bus_rdata = DATA_W'(raw_stat);
            ADDR_W'(OFF_MSKD):              bus_rdata = DATA_W'(raw_stat & mask_stat);
            default:                        bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dtt_sva.sv
// Module: checker bound to the dual timer top.
// It relates bus writes, expiry pulses and stored status over time.
module dtt_sva
    import dtt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic [1:0]        exp_vec,
    input logic [1:0]        run_vec,
    input logic [1:0]        raw_stat,
    input logic [DATA_W-1:0] cnt0,
    input logic [DATA_W-1:0] time_val
);
    // R6: an expiry of timer 0 or timer 1 shows in its raw bit next cycle
    a_r6_exp0_sets: assert property (@(posedge clk) disable iff (!rst_n)
        exp_vec[0] |=> raw_stat[0]);
    a_r6_exp1_sets: assert property (@(posedge clk) disable iff (!rst_n)
        exp_vec[1] |=> raw_stat[1]);

    // R8: an acknowledge with no competing expiry clears the bit
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_ACK) && bus_wdata[0] && !exp_vec[0])
        |=> !raw_stat[0]);

    // R7: a zero mask written drops the interrupt
    a_r7_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_MASK) && bus_wdata[1:0] == 2'b00)
        |=> !irq_o);

    // R2: a divisor write leaves a stopped count unchanged
    a_r2_div_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(SUB_DIV) && !run_vec[0])
        |=> $stable(cnt0));

    // R9: the time counter steps by one each clock
    a_r9_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> time_val == $past(time_val) + DATA_W'(1));
endmodule

bind dual_tick_timer dtt_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .exp_vec   (exp_vec),
    .run_vec   (run_vec),
    .raw_stat  (raw_stat),
    .cnt0      (cnt0),
    .time_val  (time_val)
);

// File: tb/dual_tick_timer_bench.sv
// Scoreboard bench: the read task queues expected values and a monitor
// process pops and compares them against the read port.
module dual_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_en = '0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  mon_ev;

    always #5 clk = ~clk;

    dual_tick_timer u_dual_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per read and compare.
    initial begin
        forever begin
            @(mon_ev);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        #1 ->mon_ev;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input logic [3:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = m;
            @(negedge clk);
            tick_en = '0;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    logic [31:0] t_a;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(irq_o === 1'b0, "R1 irq after reset", 32'(irq_o), 0);
        rd(7'h04, 0, "R1 count0");
        rd(7'h14, 0, "R1 count1");
        rd(7'h08, 0, "R1 ctrl0");
        rd(7'h48, 0, "R1 mask");
        rd(7'h50, 0, "R1 raw");
        rd(7'h54, 0, "R1 masked");

        // R2 divisor store only; R3 load
        wr(7'h00, 5);
        rd(7'h00, 5, "R2 div0 readback");
        rd(7'h04, 0, "R2 count untouched");
        wr(7'h08, (4 << 2) | 0);
        rd(7'h04, 5, "R3 load copies divisor");
        tick(4'b0001, 1);
        rd(7'h04, 5, "R3 loaded timer stopped");

        // R5 run on source 4
        wr(7'h08, (4 << 2) | 2);
        tick(4'b0001, 2);
        rd(7'h04, 3, "R5 two ticks");
        tick(4'b1110, 2);
        rd(7'h04, 3, "R5 unselected ticks ignored");

        // R6 expiry and reload
        tick(4'b0001, 2);
        rd(7'h04, 1, "R6 count at one");
        rd(7'h50, 0, "R6 no expiry yet");
        tick(4'b0001, 1);
        rd(7'h04, 5, "R6 reload from divisor");
        rd(7'h50, 1, "R6 raw bit0");

        // R7 mask
        @(negedge clk);
        check(irq_o === 1'b0, "R7 irq masked off", 32'(irq_o), 0);
        rd(7'h54, 0, "R7 masked zero");
        wr(7'h48, 1);
        check(irq_o === 1'b1, "R7 irq on mask", 32'(irq_o), 1);
        rd(7'h48, 1, "R7 mask readback");
        rd(7'h54, 1, "R7 masked one");

        // R8 acknowledge
        wr(7'h4C, 1);
        rd(7'h50, 0, "R8 ack clears");
        check(irq_o === 1'b0, "R8 irq after ack", 32'(irq_o), 0);

        // R4 hold; R11 op3 and source below 4
        wr(7'h08, (4 << 2) | 1);
        tick(4'b1111, 3);
        rd(7'h04, 5, "R4 hold freezes");
        wr(7'h08, (4 << 2) | 3);
        tick(4'b1111, 3);
        rd(7'h04, 5, "R11 op3 holds");
        wr(7'h08, (1 << 2) | 2);
        tick(4'b1111, 3);
        rd(7'h04, 5, "R11 source1 no advance");

        // R2 divisor write while held, then R3 reload
        wr(7'h00, 9);
        rd(7'h04, 5, "R2 count kept on div write");
        wr(7'h08, (4 << 2) | 0);
        rd(7'h04, 9, "R3 load new divisor");

        // Timer 1 on source 7: R6 bit1, R8 race
        wr(7'h10, 2);
        wr(7'h18, (7 << 2) | 0);
        wr(7'h18, (7 << 2) | 2);
        tick(4'b1000, 2);
        rd(7'h50, 2, "R6 raw bit1");
        rd(7'h14, 2, "R6 timer1 reload");
        rd(7'h54, 0, "R7 bit1 masked off");
        tick(4'b1000, 1);
        rd(7'h14, 1, "R5 timer1 step");
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = 7'h4C;
        bus_wdata = 2;
        tick_en = 4'b1000;
        @(negedge clk);
        bus_wr = 1'b0;
        tick_en = '0;
        rd(7'h50, 2, "R8 expiry beats ack");
        wr(7'h4C, 2);
        rd(7'h50, 0, "R8 plain ack bit1");

        // R10 unmapped
        wr(7'h48, 3);
        rd(7'h20, 0, "R10 unmapped read");
        wr(7'h20, 32'hFFFF_FFFF);
        rd(7'h48, 3, "R10 mask untouched");
        rd(7'h50, 0, "R10 raw untouched");
        @(negedge clk);
        check(irq_o === 1'b0, "R10 irq unchanged", 32'(irq_o), 0);

        // R9 time counter
        @(negedge clk);
        bus_addr = 7'h38;
        #1 t_a = bus_rdata;
        repeat (10) @(negedge clk);
        #1 check(bus_rdata === t_a + 10, "R9 time step", bus_rdata, t_a + 10);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule